// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block is the flow-control state machine of a four-lane register-rename stage. Every cycle decode may present a group of up to `LANES` instructions, given as a count, a per-slot "already squashed" flag and a per-slot destination-register count. The controller decides which slots of a group go downstream that cycle. It weighs several limits: the reorder-buffer and issue-queue free counts, each reduced by `LANES * FB_DELAY` to cover instructions still in flight. It also weighs the free physical-register count, and the stall and squash indications from the later stages.

When a group cannot go through whole, the group is parked in a small skid buffer and the slot where processing stopped is remembered. Later groups that decode still sends are appended to the same buffer. The controller then raises a stall toward decode and drains the buffer, oldest group first, once the downstream limits clear. A squash from commit empties the buffer and holds the stage quiet until the squash indications drop.

The five states are Idle, Running, Blocked, Unblocking and Squashing. The transitions between them are as follows:
- Idle→Running on the first group that passes whole.
- Idle/Running→Blocked on a downstream stall with a group present, or on a group cut short.
- Blocked→Unblocking when the release condition holds.
- Unblocking→Running when the last parked group is popped.
- Unblocking→Blocked on a stall or a cut-short front group.
- any→Squashing on a squash indication.
- Squashing→Running when both squash indications are low.

Instructions are opaque: the block reports slot masks, not payloads.

Top module: `rename_flow_ctrl`

## Requirements
- R1: After reset, `state_o` is Idle (encoding Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4), `stall_up` is 0 and `out_mask` is 0.
- R2: Usable credit is the smaller of (`rob_free` − LANES·FB_DELAY) and (`iq_free` − LANES·FB_DELAY). The number of slots consumed in a cycle never exceeds it. When it is zero or negative and a group is pending, nothing issues and the stage goes to Blocked.
- R3: When the credit is smaller than the number of slots left in the source group, exactly that many slots are consumed, the rest of the group is kept, and the state becomes Blocked.
- R4: Whenever the stage blocks with a decode group present, and whenever a decode group (`dec_count` > 0) arrives in Blocked or Unblocking, the group is appended to the skid buffer. Parked groups are served oldest first.
- R5: In Unblocking the source is the oldest parked group, starting at the saved slot offset. A parked group that completes is removed. `stall_up` is 1 exactly in Blocked and Unblocking. The state becomes Running when the buffer empties.
- R6: Blocked moves to Unblocking only in a cycle with no downstream stall, both credits positive and `preg_free` positive. Otherwise it stays Blocked with nothing issued.
- R7: `squash` or `rob_unwind` high in any state empties the skid buffer, clears the saved offset, issues nothing, and makes the next state Squashing.
- R8: A slot whose `dec_skip` bit is set consumes credit and input position but never appears in `out_mask`.
- R9: When a slot's destination count (`dec_dst[j*DST_W +: DST_W]`) exceeds the physical registers left after the earlier slots of that cycle, processing stops at that slot. The offset is saved and the stage goes to Blocked.
- R10: The saved offset returns to zero whenever a group completes without blocking, so the next group starts at slot 0.
- R11: Idle stays Idle while no group arrives. Squashing discards decode input and goes to Running in the first cycle both squash indications are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_count | input | CW | Number of valid slots in the decode group (0 = none) |
| dec_skip | input | LANES | Per-slot squashed flag; bit j is slot j |
| dec_dst | input | LANES*DST_W | Per-slot destination count, slot j at bits j*DST_W |
| iew_stall | input | 1 | Stall from the execute stage |
| cmt_stall | input | 1 | Stall from the commit stage |
| squash | input | 1 | Squash request from commit |
| rob_unwind | input | 1 | Reorder buffer is still squashing |
| rob_free | input | CNT_W | Reported free reorder-buffer entries |
| iq_free | input | CNT_W | Reported free issue-queue entries |
| preg_free | input | CNT_W | Free physical registers |
| out_mask | output | LANES | Slots of the source group sent downstream this cycle; bit j is slot j |
| out_from_skid | output | 1 | Source group this cycle is the oldest parked group |
| stall_up | output | 1 | Stall toward decode |
| state_o | output | 3 | Current state, encoded as in R1 |

## Verification
Two of the block's functions can fall in the same cycle. The first is the drain of the oldest parked group in Unblocking. The second is the arrival of a fresh decode group that has to be appended to the skid buffer. The bench provokes this by letting decode ignore `stall_up` at random while its model shows room in the buffer. A reference model with a queue of groups follows the same cycles and predicts which group serves each later cycle and from which offset. The bench compares the mask, source, stall and state every cycle. The same comparison also judges a squash that lands on a cycle where credit cuts a group short, since the squash must win.

// File: rtl/rn_flow_pkg.sv
package rn_flow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCK   = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } rn_state_e;

endpackage

// File: rtl/rn_skid_fifo.sv
module rn_skid_fifo #(
    parameter int DEPTH = 4,
    parameter int GW    = 15,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [GW-1:0] din,
    output logic [GW-1:0] dout,
    output logic [OW-1:0] occ,
    output logic          empty,
    output logic          full
);

    logic [GW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (occ == '0);
    assign full    = (occ == OW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
            occ  <= '0;
        end else if (clear) begin
            rd_q <= '0;
            wr_q <= '0;
            occ  <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            if (do_push && !do_pop)      occ <= occ + OW'(1);
            else if (do_pop && !do_push) occ <= occ - OW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wr_q] <= din;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear) |-> !full)
        else $error("skid buffer overflow");

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty)
        else $error("skid buffer not emptied by clear");

endmodule

// File: rtl/rn_slot_sched.sv
module rn_slot_sched #(
    parameter int LANES = 4,
    parameter int CW    = 3,
    parameter int DST_W = 2,
    parameter int CNT_W = 8
) (
    input  logic [CW-1:0]          grp_cnt,
    input  logic [CW-1:0]          base,
    input  logic [CW-1:0]          lim,
    input  logic [LANES-1:0]       skip,
    input  logic [LANES*DST_W-1:0] dst,
    input  logic [CNT_W-1:0]       preg_free,
    output logic [LANES-1:0]       mask,
    output logic [CW-1:0]          used
);

    always_comb begin
        logic [CNT_W-1:0] left;
        logic [CNT_W-1:0] need;
        logic             stop;
        mask = '0;
        used = '0;
        left = preg_free;
        stop = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            need = {{(CNT_W-DST_W){1'b0}}, dst[j*DST_W +: DST_W]};
            if (!stop && j >= int'(base) && j < int'(grp_cnt) && used < lim) begin
                if (skip[j]) begin
                    used = used + CW'(1);
                end else if (left < need) begin
                    stop = 1'b1;
                end else begin
                    mask[j] = 1'b1;
                    left    = left - need;
                    used    = used + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl
    import rn_flow_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SKID_DEPTH = 4,
    parameter int FB_DELAY   = 1,
    parameter int CNT_W      = 8,
    parameter int DST_W      = 2,
    localparam int CW        = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          dec_count,
    input  logic [LANES-1:0]       dec_skip,
    input  logic [LANES*DST_W-1:0] dec_dst,
    input  logic                   iew_stall,
    input  logic                   cmt_stall,
    input  logic                   squash,
    input  logic                   rob_unwind,
    input  logic [CNT_W-1:0]       rob_free,
    input  logic [CNT_W-1:0]       iq_free,
    input  logic [CNT_W-1:0]       preg_free,
    output logic [LANES-1:0]       out_mask,
    output logic                   out_from_skid,
    output logic                   stall_up,
    output logic [2:0]             state_o
);

    localparam int SW      = CNT_W + 2;
    localparam int RESERVE = LANES * FB_DELAY;
    localparam int GW      = LANES * DST_W + LANES + CW;
    localparam int OW      = $clog2(SKID_DEPTH + 1);

    rn_state_e state_q, state_n;
    logic [CW-1:0] off_q, off_n;

    logic sq, stall_dn;
    logic f_push, f_pop, f_clr, f_empty, f_full;
    logic [OW-1:0] f_occ;
    logic [GW-1:0] f_dout;

    logic [CW-1:0]          fr_cnt;
    logic [LANES-1:0]       fr_skip;
    logic [LANES*DST_W-1:0] fr_dst;

    logic                   use_skid;
    logic [CW-1:0]          src_cnt, base, avail, lim, used;
    logic [LANES-1:0]       src_skip, sched_mask;
    logic [LANES*DST_W-1:0] src_dst;

    logic signed [SW-1:0] rob_cr, iq_cr, min_cr, avail_s;
    logic rob_ok, iq_ok, min_ok, partial, run_cycle, release_ok;

    assign sq       = squash | rob_unwind;
    assign stall_dn = iew_stall | cmt_stall;

    // ---------------- credit arithmetic ----------------
    assign rob_cr  = $signed({2'b00, rob_free}) - $signed(SW'(RESERVE));
    assign iq_cr   = $signed({2'b00, iq_free})  - $signed(SW'(RESERVE));
    assign min_cr  = (rob_cr < iq_cr) ? rob_cr : iq_cr;
    assign rob_ok  = !rob_cr[SW-1] && (rob_cr != '0);
    assign iq_ok   = !iq_cr[SW-1]  && (iq_cr  != '0);
    assign min_ok  = rob_ok && iq_ok;

    // ---------------- source group selection ----------------
    assign fr_cnt   = f_dout[CW-1:0];
    assign fr_skip  = f_dout[CW +: LANES];
    assign fr_dst   = f_dout[CW+LANES +: LANES*DST_W];

    assign use_skid = (state_q == ST_UNBLOCK);
    assign src_cnt  = use_skid ? fr_cnt  : dec_count;
    assign src_skip = use_skid ? fr_skip : dec_skip;
    assign src_dst  = use_skid ? fr_dst  : dec_dst;
    assign base     = use_skid ? off_q   : '0;
    assign avail    = src_cnt - base;
    assign avail_s  = $signed({{(SW-CW){1'b0}}, avail});

    always_comb begin
        if (!min_ok)              lim = '0;
        else if (min_cr >= avail_s) lim = avail;
        else                      lim = CW'(min_cr);
    end

    rn_slot_sched #(
        .LANES (LANES),
        .CW    (CW),
        .DST_W (DST_W),
        .CNT_W (CNT_W)
    ) u_sched (
        .grp_cnt   (src_cnt),
        .base      (base),
        .lim       (lim),
        .skip      (src_skip),
        .dst       (src_dst),
        .preg_free (preg_free),
        .mask      (sched_mask),
        .used      (used)
    );

    assign partial    = (used < avail);
    assign release_ok = !stall_dn && min_ok && (preg_free != '0);
    assign run_cycle  = !sq && !stall_dn &&
                        ((((state_q == ST_IDLE) || (state_q == ST_RUN)) && (dec_count != '0)) ||
                         (state_q == ST_UNBLOCK));

    rn_skid_fifo #(
        .DEPTH (SKID_DEPTH),
        .GW    (GW)
    ) u_skid (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (f_clr),
        .push  (f_push),
        .pop   (f_pop),
        .din   ({dec_dst, dec_skip, dec_count}),
        .dout  (f_dout),
        .occ   (f_occ),
        .empty (f_empty),
        .full  (f_full)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n = state_q;
        off_n   = off_q;
        f_push  = 1'b0;
        f_pop   = 1'b0;
        f_clr   = 1'b0;
        if (sq) begin
            state_n = ST_SQUASH;
            off_n   = '0;
            f_clr   = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_RUN: begin
                    if (dec_count != '0) begin
                        if (stall_dn) begin
                            f_push  = 1'b1;
                            off_n   = '0;
                            state_n = ST_BLOCK;
                        end else if (partial) begin
                            f_push  = 1'b1;
                            off_n   = used;
                            state_n = ST_BLOCK;
                        end else begin
                            off_n   = '0;
                            state_n = ST_RUN;
                        end
                    end
                end
                ST_BLOCK: begin
                    f_push = (dec_count != '0);
                    if (release_ok) state_n = ST_UNBLOCK;
                end
                ST_UNBLOCK: begin
                    f_push = (dec_count != '0);
                    if (stall_dn) begin
                        state_n = ST_BLOCK;
                    end else if (partial) begin
                        off_n   = off_q + used;
                        state_n = ST_BLOCK;
                    end else begin
                        f_pop   = 1'b1;
                        off_n   = '0;
                        state_n = ((f_occ == OW'(1)) && !f_push) ? ST_RUN : ST_UNBLOCK;
                    end
                end
                ST_SQUASH: state_n = ST_RUN;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            off_q   <= '0;
        end else begin
            state_q <= state_n;
            off_q   <= off_n;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        out_mask      = run_cycle ? sched_mask : '0;
        out_from_skid = run_cycle && use_skid;
        stall_up      = (state_q == ST_BLOCK) || (state_q == ST_UNBLOCK);
        state_o       = state_q;
    end

    // ---------------- assertions ----------------
    p_no_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !min_ok |-> (out_mask == '0))
        else $error("issue without credit");

    p_drain_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_up) |-> f_empty)
        else $error("stall released with parked groups");

    p_squash_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sq |=> ((state_q == ST_SQUASH) && f_empty && (off_q == '0)))
        else $error("squash not taken");

    p_run_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (off_q == '0))
        else $error("stale offset in running state");

    p_unblock_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNBLOCK) |-> !f_empty)
        else $error("unblocking with empty skid buffer");

endmodule

// File: tb/rename_flow_ctrl_bench.sv
`timescale 1ns/1ps
module rename_flow_ctrl_bench;

    localparam int LANES = 4;
    localparam int DEPTH = 4;
    localparam int FBD   = 1;
    localparam int CNT_W = 8;
    localparam int DST_W = 2;
    localparam int CW    = 3;

    typedef struct packed {
        bit [2:0] cnt;
        bit [3:0] skip;
        bit [7:0] dst;
    } grp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] dec_count = '0;
    logic [LANES-1:0] dec_skip = '0;
    logic [LANES*DST_W-1:0] dec_dst = '0;
    logic iew_stall = 1'b0, cmt_stall = 1'b0, squash = 1'b0, rob_unwind = 1'b0;
    logic [CNT_W-1:0] rob_free = '0, iq_free = '0, preg_free = '0;
    logic [LANES-1:0] out_mask;
    logic out_from_skid, stall_up;
    logic [2:0] state_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    int   m_st  = 0;
    int   m_off = 0;
    grp_t mq[$];

    always #2.5 clk = ~clk;

    rename_flow_ctrl #(
        .LANES(LANES), .SKID_DEPTH(DEPTH), .FB_DELAY(FBD), .CNT_W(CNT_W), .DST_W(DST_W)
    ) u_rename_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_count(dec_count), .dec_skip(dec_skip),
        .dec_dst(dec_dst), .iew_stall(iew_stall), .cmt_stall(cmt_stall),
        .squash(squash), .rob_unwind(rob_unwind), .rob_free(rob_free),
        .iq_free(iq_free), .preg_free(preg_free), .out_mask(out_mask),
        .out_from_skid(out_from_skid), .stall_up(stall_up), .state_o(state_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // Reference model: evaluates the current cycle, checks outputs, then advances.
    task automatic model_step();
        grp_t src, dg;
        bit   sq, stl, use_skid, run, stop, part, push, pushed_ok;
        int   rcr, icr, mn, base, avail, lim, cons, left, d;
        bit [3:0] mask;
        bit   skip_seen;
        string tag;
        int   ns, noff;
        dg.cnt = dec_count; dg.skip = dec_skip; dg.dst = dec_dst;
        sq  = squash | rob_unwind;
        stl = iew_stall | cmt_stall;
        rcr = int'(rob_free) - LANES * FBD;
        icr = int'(iq_free) - LANES * FBD;
        mn  = (rcr < icr) ? rcr : icr;
        use_skid = (m_st == 3);
        src  = use_skid ? mq[0] : dg;
        base = use_skid ? m_off : 0;
        avail = int'(src.cnt) - base;
        lim  = (mn <= 0) ? 0 : ((mn < avail) ? mn : avail);
        cons = 0; left = int'(preg_free); stop = 0; mask = '0; skip_seen = 0;
        for (int j = base; j < int'(src.cnt); j++) begin
            if (stop || cons >= lim) break;
            d = int'(src.dst[j*2 +: 2]);
            if (src.skip[j]) begin cons++; skip_seen = 1; end
            else if (left < d) stop = 1;
            else begin mask[j] = 1'b1; left -= d; cons++; end
        end
        part = (cons < avail);
        run  = !sq && !stl && (((m_st == 0 || m_st == 1) && dg.cnt != 0) || m_st == 3);

        ns = m_st; noff = m_off; push = 0;
        if (sq) begin ns = 4; noff = 0; end
        else case (m_st)
            0, 1: if (dg.cnt != 0) begin
                if (stl) begin push = 1; noff = 0; ns = 2; end
                else if (part) begin push = 1; noff = cons; ns = 2; end
                else begin noff = 0; ns = 1; end
            end
            2: begin
                push = (dg.cnt != 0);
                if (!stl && rcr > 0 && icr > 0 && preg_free != 0) ns = 3;
            end
            3: begin
                push = (dg.cnt != 0);
                if (stl) ns = 2;
                else if (part) begin noff = m_off + cons; ns = 2; end
                else begin noff = 0; ns = (mq.size() == 1 && !push) ? 1 : 3; end
            end
            default: ns = 1;
        endcase

        if (sq) tag = "R7";
        else if (m_st == 4 || m_st == 0) tag = "R11";
        else if (m_st == 2) tag = "R6";
        else if (m_st == 3 && !stl && !part && m_off > 0) tag = "R10";
        else if (m_st == 3) tag = "R5";
        else if (run && stop) tag = "R9";
        else if (run && skip_seen) tag = "R8";
        else if (push) tag = "R4";
        else if (run && part) tag = "R3";
        else tag = "R2";

        n_checks++;
        if (out_mask !== (run ? mask : 4'b0) || out_from_skid !== (run && use_skid) ||
            stall_up !== (m_st == 2 || m_st == 3) || state_o !== 3'(m_st)) begin
            n_fails++;
            $display("FAIL %s: actual mask=%b skid=%b stall=%b state=%0d expected mask=%b skid=%b stall=%b state=%0d",
                     tag, out_mask, out_from_skid, stall_up, state_o,
                     run ? mask : 4'b0, run && use_skid, (m_st == 2 || m_st == 3), m_st);
        end

        if (sq) mq.delete();
        else begin
            pushed_ok = push;
            if (m_st == 3 && !stl && !part) void'(mq.pop_front());
            if (pushed_ok) mq.push_back(dg);
        end
        m_st = ns; m_off = noff;
    endtask

    initial begin
        int sq_hold;
        int phase_credit;
        sq_hold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        n_checks++;
        if (state_o !== 3'd0 || stall_up !== 1'b0 || out_mask !== '0) begin
            n_fails++;
            $display("FAIL R1: actual state=%0d stall=%b mask=%b expected state=0 stall=0 mask=0",
                     state_o, stall_up, out_mask);
        end
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            phase_credit = (cyc / 500) % 3;
            if (stall_up && !(($urandom % 6 == 0) && mq.size() < DEPTH)) dec_count = '0;
            else dec_count = CW'($urandom % 5);
            dec_skip = ($urandom % 3 == 0) ? LANES'($urandom) : '0;
            dec_dst  = (LANES*DST_W)'($urandom);
            iew_stall = ($urandom % 9 == 0);
            cmt_stall = ($urandom % 13 == 0);
            if (sq_hold > 0) sq_hold--;
            else if ($urandom % 60 == 0) sq_hold = 1 + $urandom % 3;
            squash     = (sq_hold > 0) && ($urandom % 2 == 0);
            rob_unwind = (sq_hold > 0) && !squash;
            case (phase_credit)
                0: begin rob_free = CNT_W'(8 + $urandom % 8); iq_free = CNT_W'(8 + $urandom % 8);
                         preg_free = CNT_W'(8 + $urandom % 8); end
                1: begin rob_free = CNT_W'($urandom % 9); iq_free = CNT_W'($urandom % 9);
                         preg_free = CNT_W'($urandom % 10); end
                default: begin rob_free = CNT_W'(4 + $urandom % 4); iq_free = CNT_W'(5 + $urandom % 6);
                         preg_free = CNT_W'($urandom % 5); end
            endcase
            #1;
            model_step();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule